// File: doc/BRIEF.md
# Indexed Statistics Counter Engine

This block keeps the traffic counters of a packet pipeline. Several pipeline stages send it update requests. A round-robin arbiter serves them, one request per cycle, and each client sees a ready line that tells it whether its request was taken. All counters are 32-bit words in one internal memory, and they fall into two groups:

- **Register counters.** A small bank of global counters, addressed directly by number. Counter 31, for example, is used for queue-manager drops.
- **Stats counters.** Each stats index owns four words. Route entries and filters each get their own index. A pipeline stage that sees a packet before queueing updates the pre-queue pair. A stage that sees it after dequeue updates the post-queue pair.

Each request names its kind, an index, a pre/post flag and a length. A stats update adds one to the packet word and adds the length to the byte word of the chosen pair. A register update adds the length to the chosen register counter. So a stage adds 1 to count packets, or the packet size to count bytes, for example on a per-port receive or transmit event.

Updates pass through a three-cycle read-modify-write pipeline. Forwarding means that back-to-back hits on the same word never lose an increment. A control-plane read port returns any word one cycle after its address is presented. A clear command zeroes the whole memory.

Top module: `statCounterEngine`

## Requirements
- R1: After reset, every counter reads 0, `rdData` is 0, and the first grant goes to client 0.
- R2: The memory layout is as follows.
  - Register counter k sits at word address k, for k below REG_COUNT.
  - Stats index i owns the four words starting at REG_COUNT+4i, in this order: +0 pre-queue packets, +1 pre-queue bytes, +2 post-queue packets, +3 post-queue bytes.
  - A stats request (`reqStat`=1) with `reqPost`=0 adds 1 to the pre-queue packet word and adds `reqLen` to the pre-queue byte word.
  - With `reqPost`=1 it does the same to the post-queue pair.
  - No other word changes.
- R3: A register request (`reqStat`=0) adds `reqLen` to register counter `reqIdx` and changes no other word.
- R4: At most one `reqReady` bit is high per cycle, and only for a client whose `reqValid` is high. After client j is granted, the next grant goes to the first requesting client found when searching upward from j+1, wrapping around.
- R5: Requests that hit the same words in consecutive cycles, from one client or from several, are all counted. No increment is lost.
- R6: While `clrReq` is high, no `reqReady` bit is high. At the next edge every counter becomes 0. Updates accepted in the two cycles just before the clear cycle are discarded.
- R7: Counters wrap modulo 2^32.
- R8: A request whose index is out of range is accepted and then dropped, and no counter changes. Out of range means an index of REG_COUNT or more for a register request, or STAT_COUNT or more for a stats request.
- R9: `rdData` shows the word at `rdAddr` one cycle after the address is presented. An address at or beyond REG_COUNT+4*STAT_COUNT reads 0. An update accepted in cycle c is readable from an address presented in cycle c+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | N_CLIENTS | Per-client request valid |
| reqStat | input | N_CLIENTS | Per-client kind: 1 stats index, 0 register counter |
| reqPost | input | N_CLIENTS | Per-client pair select: 1 post-queue, 0 pre-queue |
| reqIdx | input | N_CLIENTS*IDX_W | Per-client index, client k in bits [k*IDX_W +: IDX_W] |
| reqLen | input | N_CLIENTS*LEN_W | Per-client length, client k in bits [k*LEN_W +: LEN_W] |
| reqReady | output | N_CLIENTS | Per-client grant; a request is taken at the edge that ends a cycle where both valid and ready are high |
| clrReq | input | 1 | Clear all counters |
| rdAddr | input | RD_W | Readout word address |
| rdData | output | 32 | Readout data |

## Verification
The assertions assume the following about the inputs:
- A client holds its request fields stable while it waits for ready.
- Reset is held for at least one edge before any request.
- Clear is never asserted during reset.

The forwarding property assumes that an address in the read stage is always in range. The control logic guarantees this, because it drops out-of-range requests before they reach the datapath.

The bench keeps within these assumptions:
- It drives every input at the falling edge.
- It holds fields until an observed grant.
- It applies reset only with all requests low.
- It waits four idle cycles before any readout it compares, so only the read-visibility rule of R9 matters for its checks.

// File: rtl/statEnginePkg.sv
package statEnginePkg;
  localparam int CNT_W    = 32;
  localparam int ADDR_MAX = 16;
  localparam int LEN_MAX  = 32;

  typedef struct packed {
    logic                upd;
    logic                isStat;
    logic [ADDR_MAX-1:0] addr;
    logic [LEN_MAX-1:0]  len;
    logic                clr;
  } ctlStrobeT;
endpackage

// File: rtl/rrArbiter.sv
module rrArbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] lastIdx;
  logic [N-1:0]  gntPrev;

  always_comb begin
    logic found;
    int   cand;
    gnt   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      cand = int'(lastIdx) + k;
      if (cand >= N) cand = cand - N;
      if (!found && req[cand]) begin
        gnt[cand] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastIdx <= PW'(N - 1);
      gntPrev <= '0;
    end else begin
      gntPrev <= gnt;
      for (int k = 0; k < N; k++)
        if (gnt[k]) lastIdx <= PW'(k);
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R4
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0); // R4
  AST_RR_MOVES: assert property (@(posedge clk) disable iff (rst)
    ((gntPrev != '0) && ((req & ~gntPrev) != '0)) |-> (gnt != gntPrev)); // R4
endmodule

// File: rtl/statCtl.sv
module statCtl
  import statEnginePkg::*;
#(
  parameter int N_CLIENTS  = 3,
  parameter int IDX_W      = 8,
  parameter int LEN_W      = 16,
  parameter int REG_COUNT  = 64,
  parameter int STAT_COUNT = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_CLIENTS-1:0]         reqValid,
  input  logic [N_CLIENTS-1:0]         reqStat,
  input  logic [N_CLIENTS-1:0]         reqPost,
  input  logic [N_CLIENTS*IDX_W-1:0]   reqIdx,
  input  logic [N_CLIENTS*LEN_W-1:0]   reqLen,
  input  logic                         clrReq,
  output logic [N_CLIENTS-1:0]         reqReady,
  output ctlStrobeT                    strobe
);
  logic [N_CLIENTS-1:0] reqEff;
  logic [N_CLIENTS-1:0] gnt;
  logic                 selStat;
  logic                 selPost;
  logic [IDX_W-1:0]     selIdx;
  logic [LEN_W-1:0]     selLen;
  logic                 accepted;
  logic                 inRange;
  logic [ADDR_MAX-1:0]  selAddr;

  logic                 stgUpd;
  logic                 stgStat;
  logic [ADDR_MAX-1:0]  stgAddr;
  logic [LEN_MAX-1:0]   stgLen;

  assign reqEff = clrReq ? '0 : reqValid;

  rrArbiter #(.N(N_CLIENTS)) uArb (
    .clk (clk),
    .rst (rst),
    .req (reqEff),
    .gnt (gnt)
  );

  assign reqReady = gnt;
  assign accepted = |gnt;

  always_comb begin
    selStat = 1'b0;
    selPost = 1'b0;
    selIdx  = '0;
    selLen  = '0;
    for (int k = 0; k < N_CLIENTS; k++) begin
      if (gnt[k]) begin
        selStat = selStat | reqStat[k];
        selPost = selPost | reqPost[k];
        selIdx  = selIdx  | reqIdx[k*IDX_W +: IDX_W];
        selLen  = selLen  | reqLen[k*LEN_W +: LEN_W];
      end
    end
  end

  always_comb begin
    if (selStat) begin
      inRange = int'(selIdx) < STAT_COUNT;
      selAddr = ADDR_MAX'(REG_COUNT + 4 * int'(selIdx) + (selPost ? 2 : 0));
    end else begin
      inRange = int'(selIdx) < REG_COUNT;
      selAddr = ADDR_MAX'(selIdx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stgUpd  <= 1'b0;
      stgStat <= 1'b0;
      stgAddr <= '0;
      stgLen  <= '0;
    end else begin
      stgUpd  <= accepted && inRange;
      stgStat <= selStat;
      stgAddr <= selAddr;
      stgLen  <= LEN_MAX'(selLen);
    end
  end

  always_comb begin
    strobe.upd    = stgUpd;
    strobe.isStat = stgStat;
    strobe.addr   = stgAddr;
    strobe.len    = stgLen;
    strobe.clr    = clrReq;
  end

  AST_NO_READY_IN_CLR: assert property (@(posedge clk) disable iff (rst)
    clrReq |-> (reqReady == '0)); // R6
  AST_OOR_NOT_PASSED: assert property (@(posedge clk) disable iff (rst)
    (accepted && !selStat && int'(selIdx) >= REG_COUNT) |=> !strobe.upd); // R8
endmodule

// File: rtl/statDp.sv
module statDp
  import statEnginePkg::*;
#(
  parameter int WORDS = 128,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobeT        strobe,
  input  logic [RD_W-1:0]  rdAddr,
  output logic [CNT_W-1:0] rdData
);
  localparam int AW = $clog2(WORDS);

  logic [CNT_W-1:0]    mem [WORDS];

  logic                wrValid;
  logic                wrStat;
  logic [ADDR_MAX-1:0] wrAddrA;
  logic [CNT_W-1:0]    oldA;
  logic [CNT_W-1:0]    oldB;
  logic [CNT_W-1:0]    incA;
  logic [CNT_W-1:0]    incB;
  logic [CNT_W-1:0]    sumA;
  logic [CNT_W-1:0]    sumB;
  logic [ADDR_MAX-1:0] wrAddrB;

  logic [ADDR_MAX-1:0] rdAddrA;
  logic [ADDR_MAX-1:0] rdAddrB;
  logic [CNT_W-1:0]    fwdA;
  logic [CNT_W-1:0]    fwdB;

  assign sumA    = oldA + incA;
  assign sumB    = oldB + incB;
  assign wrAddrB = wrAddrA + ADDR_MAX'(1);
  assign rdAddrA = strobe.addr;
  assign rdAddrB = strobe.addr + ADDR_MAX'(1);

  always_comb begin
    if (wrValid && wrAddrA == rdAddrA)                fwdA = sumA;
    else if (wrValid && wrStat && wrAddrB == rdAddrA) fwdA = sumB;
    else                                              fwdA = mem[rdAddrA[AW-1:0]];
    if (wrValid && wrAddrA == rdAddrB)                fwdB = sumA;
    else if (wrValid && wrStat && wrAddrB == rdAddrB) fwdB = sumB;
    else                                              fwdB = mem[rdAddrB[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clr) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      wrValid <= 1'b0;
      wrStat  <= 1'b0;
      wrAddrA <= '0;
      oldA    <= '0;
      oldB    <= '0;
      incA    <= '0;
      incB    <= '0;
    end else begin
      if (wrValid) mem[wrAddrA[AW-1:0]] <= sumA;
      if (wrValid && wrStat) mem[wrAddrB[AW-1:0]] <= sumB;
      wrValid <= strobe.upd;
      wrStat  <= strobe.isStat;
      wrAddrA <= strobe.addr;
      oldA    <= fwdA;
      oldB    <= fwdB;
      incA    <= strobe.isStat ? CNT_W'(1) : CNT_W'(strobe.len);
      incB    <= CNT_W'(strobe.len);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (int'(rdAddr) < WORDS) rdData <= mem[rdAddr[AW-1:0]];
    else rdData <= '0;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.clr |=> (mem[0] == '0 && mem[WORDS-1] == '0)); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !strobe.clr) |=> (mem[$past(wrAddrA[AW-1:0])] == $past(sumA))); // R2
  AST_FWD_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    (strobe.upd && wrValid && !strobe.clr && strobe.addr == wrAddrA) |=> (oldA == $past(sumA))); // R5
endmodule

// File: rtl/statCounterEngine.sv
module statCounterEngine
  import statEnginePkg::*;
#(
  parameter int N_CLIENTS  = 3,
  parameter int REG_COUNT  = 64,
  parameter int STAT_COUNT = 16,
  parameter int IDX_W      = 8,
  parameter int LEN_W      = 16,
  parameter int RD_W       = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_CLIENTS-1:0]       reqValid,
  input  logic [N_CLIENTS-1:0]       reqStat,
  input  logic [N_CLIENTS-1:0]       reqPost,
  input  logic [N_CLIENTS*IDX_W-1:0] reqIdx,
  input  logic [N_CLIENTS*LEN_W-1:0] reqLen,
  output logic [N_CLIENTS-1:0]       reqReady,
  input  logic                       clrReq,
  input  logic [RD_W-1:0]            rdAddr,
  output logic [31:0]                rdData
);
  localparam int WORDS = REG_COUNT + 4 * STAT_COUNT;

  ctlStrobeT strobe;

  statCtl #(
    .N_CLIENTS (N_CLIENTS),
    .IDX_W     (IDX_W),
    .LEN_W     (LEN_W),
    .REG_COUNT (REG_COUNT),
    .STAT_COUNT(STAT_COUNT)
  ) uCtl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqStat  (reqStat),
    .reqPost  (reqPost),
    .reqIdx   (reqIdx),
    .reqLen   (reqLen),
    .clrReq   (clrReq),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  statDp #(
    .WORDS (WORDS),
    .RD_W  (RD_W)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: tb/sim_statCounterEngine.sv
module sim_statCounterEngine;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int RC = 64;
  localparam int SC = 16;
  localparam int IW = 8;
  localparam int LW = 32;
  localparam int RW = 8;
  localparam int WORDS = RC + 4 * SC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] reqValid = '0, reqStat = '0, reqPost = '0, reqReady;
  logic [NC*IW-1:0] reqIdx = '0;
  logic [NC*LW-1:0] reqLen = '0;
  logic clrReq = 1'b0;
  logic [RW-1:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  statCounterEngine #(.N_CLIENTS(NC), .REG_COUNT(RC), .STAT_COUNT(SC),
                      .IDX_W(IW), .LEN_W(LW), .RD_W(RW)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqStat(reqStat), .reqPost(reqPost),
    .reqIdx(reqIdx), .reqLen(reqLen), .reqReady(reqReady), .clrReq(clrReq),
    .rdAddr(rdAddr), .rdData(rdData));

  // Vector table: client, kind (1 stats), index, post flag, length
  localparam int NV = 8;
  localparam int vCli  [NV] = '{0, 1, 2, 0, 1, 2, 0, 1};
  localparam int vStat [NV] = '{1, 1, 0, 0, 1, 1, 0, 1};
  localparam int vIdx  [NV] = '{0, 0, 31, 0, 15, 3, 63, 3};
  localparam int vPost [NV] = '{0, 1, 0, 0, 1, 0, 0, 1};
  localparam int vLen  [NV] = '{64, 1500, 1, 40, 9000, 77, 12345, 512};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic modelApply(input int st, input int idx, input int post, input logic [31:0] len);
    int base;
    if (st != 0) begin
      if (idx < SC) begin
        base = RC + 4 * idx + (post != 0 ? 2 : 0);
        model[base]   = model[base] + 1;
        model[base+1] = model[base+1] + len;
      end
    end else if (idx < RC) begin
      model[idx] = model[idx] + len;
    end
  endtask

  task automatic setClient(input int c, input int st, input int idx, input int post, input logic [31:0] len);
    reqStat[c] = st[0];
    reqPost[c] = post[0];
    reqIdx[c*IW +: IW] = IW'(idx);
    reqLen[c*LW +: LW] = len;
  endtask

  task automatic issue(input int c, input int st, input int idx, input int post, input logic [31:0] len);
    @(negedge clk);
    setClient(c, st, idx, post, len);
    reqValid = '0;
    reqValid[c] = 1'b1;
    #1;
    check("R4 lone requester granted", {31'd0, reqReady[c]}, 32'd1);
    modelApply(st, idx, post, len);
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic flush();
    reqValid = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic readWord(input int a, output logic [31:0] v);
    @(negedge clk);
    rdAddr = RW'(a);
    @(posedge clk);
    @(negedge clk);
    v = rdData;
  endtask

  task automatic checkWord(input string tag, input int a);
    logic [31:0] v;
    readWord(a, v);
    check(tag, v, model[a]);
  endtask

  task automatic doReset();
    @(negedge clk);
    reqValid = '0;
    clrReq = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < WORDS; w++) model[w] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [NC-1:0] expG;
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check("R1 rdData after reset", rdData, 32'd0);
    checkWord("R1 register counter 31 zero", 31);
    checkWord("R1 last word zero", WORDS - 1);

    // R2 R3: table walk
    for (int i = 0; i < NV; i++) begin
      issue(vCli[i], vStat[i], vIdx[i], vPost[i], 32'(vLen[i]));
      flush();
      if (vStat[i] != 0) begin
        checkWord("R2 packet word", RC + 4 * vIdx[i] + 2 * vPost[i]);
        checkWord("R2 byte word",   RC + 4 * vIdx[i] + 2 * vPost[i] + 1);
        checkWord("R2 other pair untouched", RC + 4 * vIdx[i] + 2 * (1 - vPost[i]));
      end else begin
        checkWord("R3 register counter", vIdx[i]);
        checkWord("R3 neighbour untouched", vIdx[i] + 1);
      end
    end

    // R9: out-of-range read address returns 0
    readWord(200, v);
    check("R9 out-of-range read", v, 32'd0);

    // R9: update visible when the address is presented 3 cycles after acceptance
    @(negedge clk);
    setClient(0, 0, 7, 0, 32'd5);
    reqValid = 3'b001;
    rdAddr = RW'(7);
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
    modelApply(0, 7, 0, 32'd5);
    @(negedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 visible at third cycle", rdData, model[7]);

    // R5: back-to-back same words, one client
    @(negedge clk);
    setClient(0, 1, 5, 0, 32'd100);
    reqValid = 3'b001;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R5 back-to-back ready", {31'd0, reqReady[0]}, 32'd1);
      modelApply(1, 5, 0, 32'd100);
      @(negedge clk);
    end
    reqValid = '0;
    flush();
    checkWord("R5 packets after burst", RC + 20);
    checkWord("R5 bytes after burst", RC + 21);

    // R5: two clients alternating on the same register counter
    @(negedge clk);
    setClient(0, 0, 9, 0, 32'd3);
    setClient(1, 0, 9, 0, 32'd4);
    reqValid = 3'b011;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (reqReady[0]) modelApply(0, 9, 0, 32'd3);
      if (reqReady[1]) modelApply(0, 9, 0, 32'd4);
      @(negedge clk);
    end
    reqValid = '0;
    flush();
    checkWord("R5 alternating clients", 9);
    check("R5 alternating total", model[9], 32'd14);

    // R7: wrap modulo 2^32
    issue(2, 0, 40, 0, 32'hFFFF_FFF0);
    issue(2, 0, 40, 0, 32'h0000_0020);
    flush();
    readWord(40, v);
    check("R7 register wrap", v, 32'h0000_0010);
    issue(1, 1, 12, 1, 32'hFFFF_FFFF);
    issue(1, 1, 12, 1, 32'd2);
    flush();
    readWord(RC + 51, v);
    check("R7 byte word wrap", v, 32'd1);

    // R8: out-of-range indices dropped
    issue(0, 0, RC, 0, 32'd99);
    issue(1, 1, SC, 0, 32'd99);
    flush();
    checkWord("R8 reg index RC leaves word RC", RC);
    checkWord("R8 last word untouched", WORDS - 1);
    checkWord("R8 reg 63 untouched", 63);

    // R4: round-robin order after reset
    doReset();
    for (int c = 0; c < NC; c++) setClient(c, 0, 20 + c, 0, 32'd1);
    reqValid = 3'b111;
    for (int k = 0; k < 6; k++) begin
      #1;
      expG = NC'(1) << (k % 3);
      check("R4 rotation all requesting", 32'(reqReady), 32'(expG));
      for (int c = 0; c < NC; c++) if (expG[c]) modelApply(0, 20 + c, 0, 32'd1);
      @(negedge clk);
    end
    reqValid = 3'b101;
    for (int k = 0; k < 3; k++) begin
      #1;
      expG = (k == 1) ? 3'b100 : 3'b001;
      check("R4 rotation skips idle client", 32'(reqReady), 32'(expG));
      for (int c = 0; c < NC; c++) if (expG[c]) modelApply(0, 20 + c, 0, 32'd1);
      @(negedge clk);
    end
    reqValid = '0;
    flush();
    checkWord("R4 client 0 total", 20);
    checkWord("R4 client 1 total", 21);
    checkWord("R4 client 2 total", 22);

    // R6: clear
    issue(0, 1, 2, 0, 32'd50);
    flush();
    @(negedge clk);
    clrReq = 1'b1;
    reqValid = 3'b001;
    #1;
    check("R6 no ready during clear", 32'(reqReady), 32'd0);
    @(negedge clk);
    clrReq = 1'b0;
    reqValid = '0;
    for (int w = 0; w < WORDS; w++) model[w] = '0;
    flush();
    checkWord("R6 stats word cleared", RC + 8);
    checkWord("R6 register cleared", 20);
    // R6: update accepted just before the clear is discarded
    @(negedge clk);
    setClient(1, 0, 5, 0, 32'd7);
    reqValid = 3'b010;
    @(negedge clk);
    reqValid = '0;
    clrReq = 1'b1;
    @(negedge clk);
    clrReq = 1'b0;
    flush();
    checkWord("R6 pre-clear update dropped", 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule